// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This block holds two 8-bit down-counting interval timers and one free-running prescaler. Each timer reloads from its own divider, takes one of four clock-enable sources, can be held in a stop-and-load state or left running, and raises a sticky interrupt on every underflow until software acknowledges it. The second timer can be chained from underflows of the first, which yields one longer count. The prescaler is a down counter with its own reload value. Its underflow pulse is one of the clock sources a timer can select.

Software writes one control word that configures both timers at once, or writes the prescaler reload value. It reads the live timer counts and the live prescaler count. The time elapsed within a period is the divider minus the current count. As an example, a 25 kHz base tick with a divider of 250 gives a 100 Hz interrupt. The upstream fixed-rate clock enables arrive as single-cycle pulses on input pins.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both timer counts, the prescaler count and both interrupts are 0. Both timers are stopped, and every divider and reload value is 0.
- R2: A control write (wr_sel=0) in which a timer's run bit is 0 loads that timer's divider into its count on the next edge. The count then holds while clock enables arrive. The control word carries 12 bits per timer, with timer n at bits 12n+11..12n: divider in bits 7..0, run bit 8, clear bit 9, source in bits 11..10.
- R3: A running timer decrements by one on each cycle in which its selected enable is high.
- R4: On a tick that finds a running timer at count 1, the counter reloads its divider on the same edge and sets its interrupt.
- R5: A counter does not change on a cycle in which its selected enable is low. An enable that the timer has not selected has no effect.
- R6: A control write with a timer's clear bit set to 1 clears that timer's interrupt. A clear bit of 0 leaves the interrupt as it is.
- R7: If an underflow and a clear of the same timer fall in the same cycle, the interrupt ends up set.
- R8: A divider of 0 acts as 256. Starting from count 0, the first tick gives 255, and the underflow comes on the 256th tick.
- R9: A prescaler write (wr_sel=1) stores the low 16 bits as the reload value and loads them into the prescaler count. Each prescaler source tick decrements the count. A tick at count 1 reloads the count and emits one flexible-source pulse. Source code 3 selects that pulse.
- R10: Timer 1 with source code 2 ticks once per timer 0 underflow. The wrap output pulses in each cycle in which a timer underflows.
- R11: Source code 0 selects tick_fast and code 1 selects tick_slow. For timer 0, code 2 selects no source, so the timer never advances.
- R12: A control write whose run bit is 1 does not load the count. A timer already running keeps counting under its old settings in that cycle, and the new divider applies from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the prescaler reload |
| wr_data | input | 24 | Write data |
| tick_fast | input | 1 | Fast fixed-rate clock enable (source 0) |
| tick_slow | input | 1 | Slow fixed-rate clock enable (source 1) |
| tick_presc_src | input | 1 | Clock enable that steps the prescaler |
| t0_count | output | 8 | Live count of timer 0 |
| t1_count | output | 8 | Live count of timer 1 |
| pre_count | output | 16 | Live prescaler count |
| irq | output | 2 | Sticky interrupt per timer, bit n for timer n |
| wrap | output | 2 | Single-cycle underflow pulse per timer |

## Verification
A wrong count or a misrouted clock enable shows on the count outputs at the first edge after the tick it mishandles, because every counter is a single register fed straight from its enable. A wrong reload or divider decode stays hidden until the next underflow, and it then appears as a wrong count together with a missing or early interrupt. A fault on the cascade path appears only on timer 1's count and interrupt, one timer-0 period later. The tests therefore step the timers across each underflow and sample the outputs one cycle after every tick.

// File: rtl/dit_pkg.sv
package dit_pkg;

    localparam int CNT_W = 8;
    localparam int TMR_N = 2;

    typedef enum logic [1:0] {
        SRC_FAST  = 2'd0,
        SRC_SLOW  = 2'd1,
        SRC_CHAIN = 2'd2,
        SRC_PRESC = 2'd3
    } clk_src_e;

    typedef struct packed {
        clk_src_e           src;
        logic               clr;
        logic               run;
        logic [CNT_W-1:0]   div;
    } tmr_cfg_t;

    localparam int CFG_W  = $bits(tmr_cfg_t);
    localparam int DATA_W = TMR_N * CFG_W;

    function automatic tmr_cfg_t cfg_slice(input logic [DATA_W-1:0] word, input int idx);
        return tmr_cfg_t'(word[idx*CFG_W +: CFG_W]);
    endfunction

endpackage

// File: rtl/dit_prescaler.sv
module dit_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wr_val,
    input  logic         src_tick,
    output logic [W-1:0] count,
    output logic [W-1:0] reload,
    output logic         pulse
);
    logic at_one;

    assign at_one = (count == W'(1));
    assign pulse  = src_tick && at_one && !wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            reload <= '0;
        end else if (wr) begin
            count  <= wr_val;
            reload <= wr_val;
        end else if (src_tick) begin
            count  <= at_one ? reload : count - W'(1);
        end
    end
endmodule

// File: rtl/dit_src_mux.sv
module dit_src_mux
    import dit_pkg::*;
(
    input  clk_src_e sel,
    input  logic     fast,
    input  logic     slow,
    input  logic     chain,
    input  logic     presc,
    output logic     tick
);
    always_comb begin
        unique case (sel)
            SRC_FAST:  tick = fast;
            SRC_SLOW:  tick = slow;
            SRC_CHAIN: tick = chain;
            SRC_PRESC: tick = presc;
            default:   tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic [W-1:0] div,
    input  logic         tick,
    input  logic         clr_irq,
    output logic [W-1:0] count,
    output logic         uflow,
    output logic         irq
);
    logic step;

    assign step  = run && tick;
    assign uflow = step && (count == W'(1)) && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            irq   <= 1'b0;
        end else begin
            if (load) begin
                count <= load_val;
            end else if (step) begin
                count <= (count == W'(1)) ? div : count - W'(1);
            end
            if (uflow) begin
                irq <= 1'b1;
            end else if (clr_irq) begin
                irq <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import dit_pkg::*;
#(
    parameter int PRE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  wr_sel,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  tick_fast,
    input  logic                  tick_slow,
    input  logic                  tick_presc_src,
    output logic [CNT_W-1:0]      t0_count,
    output logic [CNT_W-1:0]      t1_count,
    output logic [PRE_W-1:0]      pre_count,
    output logic [TMR_N-1:0]      irq,
    output logic [TMR_N-1:0]      wrap
);
    logic                 ctrl_wr;
    logic                 pre_wr;
    logic                 pre_pulse;
    logic [PRE_W-1:0]     pre_reload_w;
    tmr_cfg_t             cfg_q  [TMR_N];
    tmr_cfg_t             cfg_in [TMR_N];
    logic [TMR_N-1:0]     tick_w;
    logic [TMR_N-1:0]     uflow_w;
    logic [TMR_N-1:0]     chain_w;
    logic [CNT_W-1:0]     cnt_w  [TMR_N];

    assign ctrl_wr = wr_en && !wr_sel;
    assign pre_wr  = wr_en &&  wr_sel;

    dit_prescaler #(.W(PRE_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .wr       (pre_wr),
        .wr_val   (wr_data[PRE_W-1:0]),
        .src_tick (tick_presc_src),
        .count    (pre_count),
        .reload   (pre_reload_w),
        .pulse    (pre_pulse)
    );

    for (genvar i = 0; i < TMR_N; i++) begin : g_tmr
        if (i == 0) begin : g_head
            assign chain_w[i] = 1'b0;
        end else begin : g_link
            assign chain_w[i] = uflow_w[i-1];
        end

        assign cfg_in[i] = cfg_slice(wr_data, i);

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[i] <= '0;
            end else if (ctrl_wr) begin
                cfg_q[i] <= cfg_in[i];
            end
        end

        dit_src_mux u_mux (
            .sel   (cfg_q[i].src),
            .fast  (tick_fast),
            .slow  (tick_slow),
            .chain (chain_w[i]),
            .presc (pre_pulse),
            .tick  (tick_w[i])
        );

        dit_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load     (ctrl_wr && !cfg_in[i].run),
            .load_val (cfg_in[i].div),
            .run      (cfg_q[i].run),
            .div      (cfg_q[i].div),
            .tick     (tick_w[i]),
            .clr_irq  (ctrl_wr && cfg_in[i].clr),
            .count    (cnt_w[i]),
            .uflow    (uflow_w[i]),
            .irq      (irq[i])
        );
    end

    assign wrap     = uflow_w;
    assign t0_count = cnt_w[0];
    assign t1_count = cnt_w[1];
endmodule

// File: rtl/dual_interval_timer_chk.sv
module dual_interval_timer_chk
    import dit_pkg::*;
#(
    parameter int PRE_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ctrl_wr,
    input logic             pre_wr,
    input logic [CNT_W-1:0] wr_div0,
    input logic             wr_run0,
    input logic             wr_clr0,
    input logic             tick_presc_src,
    input logic             tick0,
    input logic             run0,
    input logic [CNT_W-1:0] div0,
    input logic [CNT_W-1:0] t0_count,
    input logic [PRE_W-1:0] pre_count,
    input logic [PRE_W-1:0] pre_reload,
    input logic             irq0
);
    AST_STOP_LOADS_DIV: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && !wr_run0 |=> t0_count == $past(wr_div0)); // R2

    AST_UFLOW_RELOADS: assert property (@(posedge clk) disable iff (rst)
        run0 && tick0 && t0_count == CNT_W'(1) && !ctrl_wr |=> irq0 && t0_count == $past(div0)); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !tick0 && !ctrl_wr |=> $stable(t0_count)); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        irq0 && !(ctrl_wr && wr_clr0) |=> irq0); // R6

    AST_PRE_WRAP: assert property (@(posedge clk) disable iff (rst)
        tick_presc_src && pre_count == PRE_W'(1) && !pre_wr |=> pre_count == $past(pre_reload)); // R9
endmodule

bind dual_interval_timer dual_interval_timer_chk #(.PRE_W(PRE_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .ctrl_wr        (ctrl_wr),
    .pre_wr         (pre_wr),
    .wr_div0        (wr_data[7:0]),
    .wr_run0        (wr_data[8]),
    .wr_clr0        (wr_data[9]),
    .tick_presc_src (tick_presc_src),
    .tick0          (tick_w[0]),
    .run0           (cfg_q[0].run),
    .div0           (cfg_q[0].div),
    .t0_count       (t0_count),
    .pre_count      (pre_count),
    .pre_reload     (pre_reload_w),
    .irq0           (irq[0])
);

// File: tb/dual_interval_timer_test.sv
module dual_interval_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [23:0] wr_data = '0;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        tick_presc_src = 1'b0;
    logic [7:0]  t0_count;
    logic [7:0]  t1_count;
    logic [15:0] pre_count;
    logic [1:0]  irq;
    logic [1:0]  wrap;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    dual_interval_timer uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tick_fast(tick_fast), .tick_slow(tick_slow), .tick_presc_src(tick_presc_src),
        .t0_count(t0_count), .t1_count(t1_count), .pre_count(pre_count),
        .irq(irq), .wrap(wrap)
    );

    function automatic logic [11:0] tf(input int dv, input bit run, input bit clr, input int src);
        return {src[1:0], clr, run, dv[7:0]};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [11:0] c0, input logic [11:0] c1);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = {c1, c0};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_pre(input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 24'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: tick_fast = 1'b1;
            1: tick_slow = 1'b1;
            default: tick_presc_src = 1'b1;
        endcase
        @(negedge clk);
        tick_fast = 1'b0; tick_slow = 1'b0; tick_presc_src = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 t0_count", t0_count, 0);
        check("R1 t1_count", t1_count, 0);
        check("R1 pre_count", pre_count, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_stop_load;
        wr_ctrl(tf(5, 0, 0, 0), tf(0, 0, 0, 0));
        check("R2 load", t0_count, 5);
        pulse(0); pulse(0);
        check("R2 held", t0_count, 5);
    endtask

    task automatic t_run_uflow;
        wr_ctrl(tf(5, 1, 0, 0), tf(0, 0, 0, 0));
        check("R12 run write keeps count", t0_count, 5);
        for (int k = 4; k >= 1; k--) begin
            pulse(0);
            check("R3 decrement", t0_count, k);
        end
        repeat (3) @(negedge clk);
        check("R5 idle hold", t0_count, 1);
        pulse(1);
        check("R5 unselected enable", t0_count, 1);
        check("R4 no irq before", irq[0], 0);
        pulse(0);
        check("R4 reload", t0_count, 5);
        check("R4 irq set", irq[0], 1);
    endtask

    task automatic t_clear;
        wr_ctrl(tf(5, 1, 0, 0), tf(0, 0, 0, 0));
        check("R6 noop keeps irq", irq[0], 1);
        wr_ctrl(tf(5, 1, 1, 0), tf(0, 0, 0, 0));
        check("R6 clear", irq[0], 0);
    endtask

    task automatic t_set_wins;
        wr_ctrl(tf(3, 0, 0, 0), tf(0, 0, 0, 0));
        wr_ctrl(tf(3, 1, 0, 0), tf(0, 0, 0, 0));
        pulse(0); pulse(0);
        check("R7 setup count", t0_count, 1);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = {tf(0, 0, 0, 0), tf(9, 1, 1, 0)};
        tick_fast = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_fast = 1'b0;
        check("R7 set beats clear", irq[0], 1);
        check("R12 old divider used", t0_count, 3);
        pulse(0); pulse(0);
        pulse(0);
        check("R12 new divider at next reload", t0_count, 9);
        wr_ctrl(tf(9, 1, 1, 0), tf(0, 0, 0, 0));
    endtask

    task automatic t_div_zero;
        wr_ctrl(tf(0, 0, 0, 0), tf(0, 0, 0, 0));
        check("R8 load zero", t0_count, 0);
        wr_ctrl(tf(0, 1, 0, 0), tf(0, 0, 0, 0));
        pulse(0);
        check("R8 first tick", t0_count, 255);
        for (int k = 0; k < 254; k++) pulse(0);
        check("R8 before underflow", t0_count, 1);
        check("R8 no irq yet", irq[0], 0);
        pulse(0);
        check("R8 irq at 256", irq[0], 1);
        check("R8 reload zero", t0_count, 0);
        wr_ctrl(tf(0, 0, 1, 0), tf(0, 0, 0, 0));
    endtask

    task automatic t_slow_src;
        wr_ctrl(tf(4, 0, 0, 1), tf(0, 0, 0, 0));
        wr_ctrl(tf(4, 1, 0, 1), tf(0, 0, 0, 0));
        pulse(0);
        check("R11 fast ignored on slow src", t0_count, 4);
        pulse(1);
        check("R11 slow source ticks", t0_count, 3);
    endtask

    task automatic t_chain_t0;
        wr_ctrl(tf(4, 0, 0, 2), tf(0, 0, 0, 0));
        wr_ctrl(tf(4, 1, 0, 2), tf(0, 0, 0, 0));
        pulse(0); pulse(1); pulse(2);
        check("R11 timer0 code2 never ticks", t0_count, 4);
    endtask

    task automatic t_presc;
        wr_pre(3);
        check("R9 pre load", pre_count, 3);
        wr_ctrl(tf(2, 0, 0, 3), tf(0, 0, 0, 0));
        wr_ctrl(tf(2, 1, 0, 3), tf(0, 0, 0, 0));
        pulse(2);
        check("R9 pre dec", pre_count, 2);
        pulse(2);
        check("R9 pre at one", pre_count, 1);
        check("R9 timer waits", t0_count, 2);
        pulse(2);
        check("R9 pre reload", pre_count, 3);
        check("R9 flexible pulse ticks timer", t0_count, 1);
    endtask

    task automatic t_cascade;
        wr_ctrl(tf(2, 0, 1, 0), tf(2, 0, 1, 2));
        wr_ctrl(tf(2, 1, 0, 0), tf(2, 1, 0, 2));
        check("R10 t1 loaded", t1_count, 2);
        pulse(0);
        check("R10 t1 idle", t1_count, 2);
        @(negedge clk);
        tick_fast = 1'b1;
        #1;
        check("R10 wrap pulse", wrap, 2'b01);
        @(negedge clk);
        tick_fast = 1'b0;
        check("R10 t1 step", t1_count, 1);
        pulse(0);
        check("R10 no irq1 yet", irq[1], 0);
        pulse(0);
        check("R10 irq1 set", irq[1], 1);
        check("R10 t1 reload", t1_count, 2);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_stop_load();
                t_run_uflow();
                t_clear();
                t_set_wins();
                t_div_zero();
                t_slow_src();
                t_chain_t0();
                t_presc();
                t_cascade();
            end
            begin
                repeat (200000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule